// File: doc/BRIEF.md
# Debug Transport Register Front End

This block is the register file that an external debugger reaches inside a processor debug unit. A simple request port (word address, 32-bit write data, read strobe, write strobe) gives access to a control word, a hart status word, a command status word, a command word, an auto-execute mask, a small set of data words and a set of program-buffer words. Many accesses have side effects. Writing the control word can reset the whole unit. Touching a data word while a command runs records an error. The error field is cleared by writing ones. Words marked for auto-execution re-issue the stored command whenever they are read or written.

The hart side arrives as per-hart vectors for "halted", "present" and "resumed" events. The block reports the state of the one hart that the control word selects. Toward the harts it drives a one-hot halt request and per-hart pending-resume flags. Toward the command generator it gives a one-cycle issue pulse with the stored command word. It takes back a busy level and an error report. Decoding the command and the hart-side memory window belong to other blocks.

Top module: `dbg_regfront`

## Requirements
- R1: After reset, a read of the status word (address 0x11) returns version 2 in bits [3:0] and authenticated in bit 7. A read of the command status word (0x16) returns NDATA in bits [3:0], NPROG in bits [28:24], error code 0 in bits [10:8] and the `cmd_busy` input in bit 12.
- R2: A write to the control word (0x10) with bit 0 (active) set captures halt request (bit 31), resume request (bit 30), hart select (bits [19:16]) and system reset (bit 1). These read back in the same positions. `halt_req` then has exactly the bit of the selected hart set while halt request is on, and `dm_active` and `sys_reset` follow their bits.
- R3: A write to the control word with bit 0 clear returns the control word, the error code and the auto-execute mask to zero. Data and program-buffer contents are kept.
- R4: A write to the command status word clears each error-code bit whose matching bit of wdata[10:8] is 1 and leaves the others unchanged.
- R5: A read or write of a data word (0x04 upward) while `cmd_busy` is high sets the error code to 1 (busy), but only when the error code is 0.
- R6: A write to the command word (0x17) stores it and raises `cmd_go` for one cycle, with `cmd_word` equal to the stored word, on the clock edge that ends the access. This happens only when the error code is 0 and `cmd_busy` is low. When busy, the error code becomes 1 instead. The command word reads back as 0.
- R7: The auto-execute word (0x18) holds one bit per data word in bits [NDATA-1:0] and one bit per program-buffer word (0x20 upward) in bits [16+NPROG-1:16]. Any read or write of a word whose bit is set issues the stored command under the same conditions as R6. Words whose bit is clear issue nothing.
- R8: The status word reports the selected hart. If the hart is present (index below NHARTS and its `hart_present` bit set), it sets halted (bits 9 and 8) when `hart_halted` is high and running (bits 11 and 10) otherwise. If the hart is missing, it sets nonexistent (bits 15 and 14). In each pair the "any" bit equals the "all" bit.
- R9: A control write with active and resume request set, to a present hart, sets that hart's `resume_pend` and clears its acknowledge. A `hart_resumed` pulse clears the pending flag and sets the acknowledge. Status bits 17 and 16 are 1 only for a present selected hart whose acknowledge is set.
- R10: Every read strobe gives `rsp_valid` exactly one cycle later with the data. An unmapped address gives `rsp_err` = 1 and data 0.
- R11: A `gen_err_valid` report loads `gen_err_code` into the error code only when the error code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | 7 | Word address of the access |
| req_wdata | input | 32 | Write data |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| rsp_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Read of an unmapped address |
| hart_halted | input | NHARTS | Per-hart halted state |
| hart_present | input | NHARTS | Per-hart existence |
| hart_resumed | input | NHARTS | Per-hart resume acknowledge pulse |
| cmd_busy | input | 1 | Command generator busy |
| gen_err_valid | input | 1 | Command generator reports an error |
| gen_err_code | input | 3 | Reported error code |
| cmd_go | output | 1 | One-cycle command issue pulse |
| cmd_word | output | 32 | Stored command word |
| halt_req | output | NHARTS | Halt request to the selected hart |
| resume_pend | output | NHARTS | Per-hart pending resume flags |
| dm_active | output | 1 | Unit active bit |
| sys_reset | output | 1 | System reset request |

## Verification
Read data is due on the cycle after the read strobe, so each read task raises the strobe at a falling edge and samples `rsp_rdata` and `rsp_err` at the next falling edge. Register side effects, `cmd_go`, `halt_req` and `resume_pend` change on the rising edge that ends the access. The bench checks them at the falling edge that closes the write or read task, and any state that can only be seen through a register is read back in a later access. A `hart_resumed` or `gen_err_valid` pulse is held for one full cycle, and its effect is observed through the next read.

// File: rtl/dbg_regfront_pkg.sv
package dbg_regfront_pkg;

    localparam int AW    = 7;
    localparam int SEL_W = 4;

    localparam logic [AW-1:0] ADR_DATA0 = 7'h04;
    localparam logic [AW-1:0] ADR_CTRL  = 7'h10;
    localparam logic [AW-1:0] ADR_STAT  = 7'h11;
    localparam logic [AW-1:0] ADR_ACS   = 7'h16;
    localparam logic [AW-1:0] ADR_CMD   = 7'h17;
    localparam logic [AW-1:0] ADR_AUTO  = 7'h18;
    localparam logic [AW-1:0] ADR_PROG0 = 7'h20;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUSY = 3'd1;
    localparam logic [3:0] SPEC_VER = 4'd2;

    typedef struct packed {
        logic haltreq;
        logic resumereq;
        logic [SEL_W-1:0] sel;
        logic sysrst;
        logic active;
    } ctrl_t;

    typedef struct packed {
        logic nonexist;
        logic halted;
        logic running;
        logic resack;
    } hart_view_t;

    function automatic logic [31:0] pack_status(hart_view_t v);
        logic [31:0] w;
        w        = '0;
        w[3:0]   = SPEC_VER;
        w[7]     = 1'b1;
        w[9:8]   = {2{v.halted}};
        w[11:10] = {2{v.running}};
        w[15:14] = {2{v.nonexist}};
        w[17:16] = {2{v.resack}};
        return w;
    endfunction

    function automatic logic [31:0] pack_ctrl(ctrl_t c);
        logic [31:0] w;
        w               = '0;
        w[31]           = c.haltreq;
        w[30]           = c.resumereq;
        w[16 +: SEL_W]  = c.sel;
        w[1]            = c.sysrst;
        w[0]            = c.active;
        return w;
    endfunction

endpackage

// File: rtl/dbg_hartview.sv
module dbg_hartview
    import dbg_regfront_pkg::*;
#(
    parameter int NHARTS = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NHARTS-1:0] halted,
    input  logic [NHARTS-1:0] present,
    input  logic [NHARTS-1:0] ack,
    output hart_view_t        view
);
    always_comb begin
        logic ex, hl, ak;
        ex = 1'b0;
        hl = 1'b0;
        ak = 1'b0;
        for (int i = 0; i < NHARTS; i++) begin
            if (sel == SEL_W'(i)) begin
                ex = present[i];
                hl = halted[i];
                ak = ack[i];
            end
        end
        view.nonexist = !ex;
        view.halted   = ex && hl;
        view.running  = ex && !hl;
        view.resack   = ex && ak;
    end
endmodule

// File: rtl/dbg_hartstate.sv
module dbg_hartstate
    import dbg_regfront_pkg::*;
#(
    parameter int NHARTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              resume_req,
    input  logic [SEL_W-1:0]  resume_sel,
    input  logic [NHARTS-1:0] present,
    input  logic [NHARTS-1:0] resumed,
    output logic [NHARTS-1:0] pend,
    output logic [NHARTS-1:0] ack
);
    for (genvar g = 0; g < NHARTS; g++) begin : g_hart
        logic hit;
        assign hit = resume_req && (resume_sel == SEL_W'(g)) && present[g];
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= 1'b0;
                ack[g]  <= 1'b0;
            end else if (hit) begin
                pend[g] <= 1'b1;
                ack[g]  <= 1'b0;
            end else if (resumed[g]) begin
                pend[g] <= 1'b0;
                ack[g]  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_errfield.sv
module dbg_errfield
    import dbg_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       clr_en,
    input  logic [2:0] clr_mask,
    input  logic       set_busy,
    input  logic       gen_valid,
    input  logic [2:0] gen_code,
    output logic [2:0] err
);
    logic [2:0] err_d;

    always_comb begin
        err_d = err;
        if (clr_en)
            err_d = err & ~clr_mask;
        if (err == ERR_NONE) begin
            if (set_busy)
                err_d = ERR_BUSY;
            else if (gen_valid)
                err_d = gen_code;
        end
        if (soft_rst)
            err_d = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= ERR_NONE;
        else     err <= err_d;
    end
endmodule

// File: rtl/dbg_regfront.sv
module dbg_regfront
    import dbg_regfront_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int NDATA  = 2,
    parameter int NPROG  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_rd,
    input  logic              req_wr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [NHARTS-1:0] hart_halted,
    input  logic [NHARTS-1:0] hart_present,
    input  logic [NHARTS-1:0] hart_resumed,
    input  logic              cmd_busy,
    input  logic              gen_err_valid,
    input  logic [2:0]        gen_err_code,
    output logic              cmd_go,
    output logic [31:0]       cmd_word,
    output logic [NHARTS-1:0] halt_req,
    output logic [NHARTS-1:0] resume_pend,
    output logic              dm_active,
    output logic              sys_reset
);
    localparam int AUTO_PB = 16;

    ctrl_t             ctrl_q;
    logic [NDATA-1:0]  auto_d_q;
    logic [NPROG-1:0]  auto_p_q;
    logic [31:0]       data_q [NDATA];
    logic [31:0]       prog_q [NPROG];
    logic [31:0]       cmd_q;
    logic [2:0]        cmd_err;
    logic [NHARTS-1:0] res_ack;
    hart_view_t        view;

    logic              acc;
    logic [NDATA-1:0]  hit_d;
    logic [NPROG-1:0]  hit_p;
    logic              wr_ctrl, soft_rst, trigger, data_touch, issue;

    assign acc = req_rd || req_wr;

    always_comb begin
        for (int i = 0; i < NDATA; i++)
            hit_d[i] = (req_addr == ADR_DATA0 + AW'(i));
        for (int i = 0; i < NPROG; i++)
            hit_p[i] = (req_addr == ADR_PROG0 + AW'(i));
    end

    assign wr_ctrl    = req_wr && (req_addr == ADR_CTRL);
    assign soft_rst   = wr_ctrl && !req_wdata[0];
    assign data_touch = acc && (|hit_d);
    assign trigger    = (req_wr && (req_addr == ADR_CMD)) ||
                        (acc && ((|(hit_d & auto_d_q)) || (|(hit_p & auto_p_q))));
    assign issue      = trigger && (cmd_err == ERR_NONE) && !cmd_busy;

    dbg_errfield u_err (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .clr_en    (req_wr && (req_addr == ADR_ACS)),
        .clr_mask  (req_wdata[10:8]),
        .set_busy  ((data_touch || trigger) && cmd_busy),
        .gen_valid (gen_err_valid),
        .gen_code  (gen_err_code),
        .err       (cmd_err)
    );

    dbg_hartstate #(.NHARTS(NHARTS)) u_hst (
        .clk        (clk),
        .rst        (rst),
        .resume_req (wr_ctrl && req_wdata[0] && req_wdata[30]),
        .resume_sel (req_wdata[16 +: SEL_W]),
        .present    (hart_present),
        .resumed    (hart_resumed),
        .pend       (resume_pend),
        .ack        (res_ack)
    );

    dbg_hartview #(.NHARTS(NHARTS)) u_hv (
        .sel     (ctrl_q.sel),
        .halted  (hart_halted),
        .present (hart_present),
        .ack     (res_ack),
        .view    (view)
    );

    // register state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            auto_d_q <= '0;
            auto_p_q <= '0;
            cmd_q    <= '0;
            cmd_go   <= 1'b0;
            for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
            for (int i = 0; i < NPROG; i++) prog_q[i] <= '0;
        end else begin
            cmd_go <= issue;
            if (soft_rst) begin
                ctrl_q   <= '0;
                auto_d_q <= '0;
                auto_p_q <= '0;
            end else if (wr_ctrl) begin
                ctrl_q.active    <= 1'b1;
                ctrl_q.haltreq   <= req_wdata[31];
                ctrl_q.resumereq <= req_wdata[30];
                ctrl_q.sel       <= req_wdata[16 +: SEL_W];
                ctrl_q.sysrst    <= req_wdata[1];
            end
            if (req_wr && req_addr == ADR_AUTO) begin
                auto_d_q <= req_wdata[NDATA-1:0];
                auto_p_q <= req_wdata[AUTO_PB +: NPROG];
            end
            if (req_wr && req_addr == ADR_CMD)
                cmd_q <= req_wdata;
            for (int i = 0; i < NDATA; i++)
                if (req_wr && hit_d[i]) data_q[i] <= req_wdata;
            for (int i = 0; i < NPROG; i++)
                if (req_wr && hit_p[i]) prog_q[i] <= req_wdata;
        end
    end

    // read path
    logic [31:0] rd_d;
    logic        rd_bad;

    always_comb begin
        rd_d   = '0;
        rd_bad = 1'b0;
        if (|hit_d) begin
            for (int i = 0; i < NDATA; i++)
                if (hit_d[i]) rd_d = data_q[i];
        end else if (|hit_p) begin
            for (int i = 0; i < NPROG; i++)
                if (hit_p[i]) rd_d = prog_q[i];
        end else begin
            case (req_addr)
                ADR_CTRL: rd_d = pack_ctrl(ctrl_q);
                ADR_STAT: rd_d = pack_status(view);
                ADR_ACS: begin
                    rd_d[3:0]   = 4'(NDATA);
                    rd_d[10:8]  = cmd_err;
                    rd_d[12]    = cmd_busy;
                    rd_d[28:24] = 5'(NPROG);
                end
                ADR_CMD:  rd_d = '0;
                ADR_AUTO: begin
                    rd_d[NDATA-1:0]       = auto_d_q;
                    rd_d[AUTO_PB +: NPROG] = auto_p_q;
                end
                default:  rd_bad = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_rd;
            if (req_rd) begin
                rsp_rdata <= rd_d;
                rsp_err   <= rd_bad;
            end
        end
    end

    for (genvar g = 0; g < NHARTS; g++) begin : g_halt
        assign halt_req[g] = ctrl_q.active && ctrl_q.haltreq && (ctrl_q.sel == SEL_W'(g));
    end

    assign cmd_word  = cmd_q;
    assign dm_active = ctrl_q.active;
    assign sys_reset = ctrl_q.sysrst;

endmodule

// File: rtl/dbg_regfront_chk.sv
module dbg_regfront_chk
    import dbg_regfront_pkg::*;
#(
    parameter int NHARTS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     req_addr,
    input logic [31:0]       req_wdata,
    input logic              req_rd,
    input logic              req_wr,
    input logic              rsp_valid,
    input logic              cmd_go,
    input logic              dm_active,
    input logic [2:0]        err,
    input logic [NHARTS-1:0] pend,
    input logic [NHARTS-1:0] ack
);
    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        req_rd |=> rsp_valid);

    // R10
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_rd |=> !rsp_valid);

    // R6
    go_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_go) |-> $past(req_rd || req_wr));

    // R9
    pend_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pend & ack) == '0);

    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err != 3'd0) && !(req_wr && (req_addr == ADR_ACS || req_addr == ADR_CTRL))
        |=> $stable(err));

    // R2
    active_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dm_active) |-> $past(req_wr && req_addr == ADR_CTRL && req_wdata[0]));
endmodule

bind dbg_regfront dbg_regfront_chk #(.NHARTS(NHARTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .rsp_valid (rsp_valid),
    .cmd_go    (cmd_go),
    .dm_active (dm_active),
    .err       (cmd_err),
    .pend      (resume_pend),
    .ack       (res_ack)
);

// File: tb/dbg_regfront_bench.sv
module dbg_regfront_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NH-1:0] hart_halted = '0, hart_present = 4'b0111, hart_resumed = '0;
    logic        cmd_busy = 1'b0, gen_err_valid = 1'b0;
    logic [2:0]  gen_err_code = '0;
    logic        cmd_go, dm_active, sys_reset;
    logic [31:0] cmd_word;
    logic [NH-1:0] halt_req, resume_pend;

    int total = 0, bad = 0;
    logic        last_go;
    logic [31:0] rv;
    logic        re;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_regfront u_dbg_regfront (
        .clk(clk), .rst(rst), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_rd(req_rd), .req_wr(req_wr), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .hart_halted(hart_halted),
        .hart_present(hart_present), .hart_resumed(hart_resumed),
        .cmd_busy(cmd_busy), .gen_err_valid(gen_err_valid),
        .gen_err_code(gen_err_code), .cmd_go(cmd_go), .cmd_word(cmd_word),
        .halt_req(halt_req), .resume_pend(resume_pend),
        .dm_active(dm_active), .sys_reset(sys_reset)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_wr = 1'b1;
        @(negedge clk);
        req_wr = 1'b0;
        last_go = cmd_go;
    endtask

    task automatic rd(logic [6:0] a);
        @(negedge clk);
        req_addr = a; req_rd = 1'b1;
        @(negedge clk);
        req_rd = 1'b0;
        last_go = cmd_go;
        rv = rsp_rdata;
        re = rsp_err;
        total++;
        if (rsp_valid !== 1'b1) begin
            bad++;
            $display("FAIL R10: rsp_valid actual=%b expected=1", rsp_valid);
        end
    endtask

    task automatic t_reset;
        rd(7'h11); check("R1 status", rv, 32'h0000_0C82);
        rd(7'h16); check("R1 cmd status", rv, 32'h0400_0002);
        check("R1 dm_active", 32'(dm_active), 0);
    endtask

    task automatic t_ctrl;
        hart_halted = 4'b0100;
        wr(7'h10, 32'h8002_0003);
        rd(7'h10); check("R2 readback", rv, 32'h8002_0003);
        check("R2 halt_req", 32'(halt_req), 32'h4);
        check("R2 sys_reset", 32'(sys_reset), 1);
        rd(7'h11); check("R8 halted", rv, 32'h0000_0382);
        wr(7'h10, 32'h0003_0001);
        rd(7'h11); check("R8 missing hart", rv, 32'h0000_C082);
        wr(7'h10, 32'h0005_0001);
        rd(7'h11); check("R8 out of range", rv, 32'h0000_C082);
        check("R2 halt_req off", 32'(halt_req), 0);
        hart_halted = '0;
    endtask

    task automatic t_cmd;
        wr(7'h10, 32'h0000_0001);
        wr(7'h17, 32'h00AB_CDEF);
        check("R6 go", 32'(last_go), 1);
        check("R6 word", cmd_word, 32'h00AB_CDEF);
        rd(7'h17); check("R6 reads zero", rv, 0);
        check("R6 single pulse", 32'(last_go), 0);
    endtask

    task automatic t_busy;
        wr(7'h04, 32'h1111_2222);
        cmd_busy = 1'b1;
        rd(7'h04);
        rd(7'h16); check("R5 busy error", rv, 32'h0400_1102);
        wr(7'h17, 32'h0000_0005);
        check("R6 no go on error", 32'(last_go), 0);
        wr(7'h16, 32'h0000_0200);
        rd(7'h16); check("R4 zero bits keep", rv[10:8], 1);
        wr(7'h16, 32'h0000_0100);
        rd(7'h16); check("R4 one clears", rv[10:8], 0);
        wr(7'h17, 32'h0000_0006);
        check("R6 no go when busy", 32'(last_go), 0);
        rd(7'h16); check("R6 busy error", rv[10:8], 1);
        cmd_busy = 1'b0;
        wr(7'h16, 32'h0000_0700);
        rd(7'h04); check("R5 data kept", rv, 32'h1111_2222);
        rd(7'h16); check("R5 no error when idle", rv[10:8], 0);
    endtask

    task automatic t_generr;
        @(negedge clk); gen_err_valid = 1'b1; gen_err_code = 3'd3;
        @(negedge clk); gen_err_code = 3'd2;
        @(negedge clk); gen_err_valid = 1'b0;
        rd(7'h16); check("R11 first error kept", rv[10:8], 3);
        cmd_busy = 1'b1;
        rd(7'h05);
        cmd_busy = 1'b0;
        rd(7'h16); check("R5 busy not over error", rv[10:8], 3);
        wr(7'h16, 32'h0000_0700);
    endtask

    task automatic t_auto;
        wr(7'h18, 32'h0001_0002);
        rd(7'h18); check("R7 mask readback", rv, 32'h0001_0002);
        wr(7'h05, 32'hCAFE_0001);
        check("R7 data write go", 32'(last_go), 1);
        rd(7'h05); check("R7 data read", rv, 32'hCAFE_0001);
        check("R7 data read go", 32'(last_go), 1);
        rd(7'h04); check("R7 clear bit no go", 32'(last_go), 0);
        rd(7'h20); check("R7 progbuf go", 32'(last_go), 1);
        wr(7'h21, 32'h0000_0013);
        check("R7 progbuf clear bit", 32'(last_go), 0);
        wr(7'h10, 32'h0000_0000);
        rd(7'h18); check("R3 mask cleared", rv, 0);
        rd(7'h10); check("R3 ctrl cleared", rv, 0);
        rd(7'h05); check("R3 data kept", rv, 32'hCAFE_0001);
        check("R3 inactive", 32'(dm_active), 0);
    endtask

    task automatic t_resume;
        wr(7'h10, 32'h4001_0001);
        check("R9 pending", 32'(resume_pend), 32'h2);
        rd(7'h11); check("R9 no ack yet", rv, 32'h0000_0C82);
        @(negedge clk); hart_resumed = 4'b0010;
        @(negedge clk); hart_resumed = '0;
        check("R9 pending cleared", 32'(resume_pend), 0);
        rd(7'h11); check("R9 ack", rv, 32'h0003_0C82);
        wr(7'h10, 32'h4001_0001);
        rd(7'h11); check("R9 ack cleared", rv, 32'h0000_0C82);
        wr(7'h10, 32'h4003_0001);
        check("R9 missing hart", 32'(resume_pend), 32'h2);
    endtask

    task automatic t_unmapped;
        rd(7'h3F);
        check("R10 err", 32'(re), 1);
        check("R10 data zero", rv, 0);
        rd(7'h18);
        check("R10 mapped no err", 32'(re), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_cmd();
        t_busy();
        t_generr();
        t_auto();
        t_resume();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule